// File: doc/BRIEF.md
# Tag Memory Bank Access Controller

This block owns the word-organised memory of a passive identification tag: 432 bits held as 27 registers of 16 bits each. The memory is split into logical banks that are selected by a 2-bit code. A parameter chosen at elaboration picks one of two partitions. The three-bank partition has a reserved bank, a large item-code bank and an identification bank. The four-bank partition shrinks the item-code bank to make room for a user bank.

A command decoder upstream issues one request at a time. A request gives an operation code, a bank, a word pointer relative to that bank, a word count and up to four data words. The controller turns the bank-relative pointer into a physical word address and checks the whole range against the active partition. It then either streams read words out one per cycle or stores words one per cycle. Each request ends with a single-cycle done or error pulse. Inside the reserved bank, words 0–1 hold the kill password and words 2–3 hold the access password. Inside the item-code bank, word 0 is the checksum, word 1 the protocol-control word and the item code starts at word 2. The controller does not interpret any of these words.

The controller is a state machine with five states. S_IDLE waits for a request. S_READ emits one word per cycle. S_STORE writes one word per cycle. S_DONE pulses done. S_FAIL pulses err. From S_IDLE, a valid request goes to S_FAIL when the range check fails, to S_READ for a read, and to S_STORE otherwise. S_READ and S_STORE move to S_DONE after their last word. S_DONE and S_FAIL return to S_IDLE.

Top module: `tag_bank_ctrl`

## Requirements
- R1: After reset the block is idle with busy, rd_valid, done and err low. Every word reads 0000h except the first identification word.
- R2: Bank codes are 00 reserved (4 words), 01 item code (19 words, or 11 words in the four-bank partition) and 10 identification (4 words). Code 11 is user (8 words, four-bank partition only). req_ptr is a word offset inside the selected bank.
- R3: A read (req_op 00) of N words asserts rd_valid for N consecutive cycles starting the cycle after acceptance, in ascending word order. done follows in the next cycle.
- R4: A single write (req_op 01) stores req_wdata[15:0] at the pointer, ignores req_cnt, and pulses done two cycles after acceptance.
- R5: A block write (req_op 10) stores 1 to 4 words, word i taken from req_wdata[16i+15:16i]. A count of 0 or above 4 is an error.
- R6: A block erase (req_op 11) sets N consecutive words to 0000h, for any N up to the full bank size. done comes N+1 cycles after acceptance.
- R7: A request with an effective count of zero, or whose pointer plus count exceeds the bank size, pulses err one cycle after acceptance and changes no word.
- R8: In the three-bank partition, every request to bank 11 is rejected with err.
- R9: Writes and erases aimed at the identification bank are rejected with err. Its first word always reads E002h.
- R10: done and err are one-cycle pulses and are never high together. busy is high from the cycle after acceptance until the block is idle again, and requests presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; accepted only while idle |
| req_op | input | 2 | 00 read, 01 write, 10 block write, 11 block erase |
| req_bank | input | 2 | Bank selector |
| req_ptr | input | PTR_W | Word offset inside the bank |
| req_cnt | input | CNT_W | Word count |
| req_wdata | input | BLK_MAX*16 | Write words, word i in bits 16i+15:16i |
| busy | output | 1 | Request in progress |
| rd_valid | output | 1 | rd_data carries a read word |
| rd_data | output | 16 | Read word |
| done | output | 1 | Request completed |
| err | output | 1 | Request rejected |

## Verification
The bench builds two copies side by side and drives them with the same stimulus: `dut` with FOUR_BANK=0 and `dut4` with FOUR_BANK=1. The three-bank copy reaches bank 11 rejection and the 19-word item-code bank, including erases that span the whole bank. The four-bank copy reaches the user bank and the shorter item-code bank. A single request can therefore succeed on one copy and fail its range check on the other, which exercises both sides of the bound at the same pointer.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

    localparam int WORD_W      = 16;
    localparam int TOTAL_BITS  = 432;
    localparam int TOTAL_WORDS = TOTAL_BITS / WORD_W;
    localparam int RSV_WORDS   = 4;
    localparam int TID_WORDS   = 4;
    localparam int USR_WORDS   = 8;
    localparam int BLK_MAX     = 4;
    localparam logic [WORD_W-1:0] ID_WORD = 16'hE002;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_BLKWR = 2'b10,
        OP_ERASE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        BANK_RSV = 2'b00,
        BANK_EPC = 2'b01,
        BANK_TID = 2'b10,
        BANK_USR = 2'b11
    } bank_e;

    function automatic int epc_words(input bit four);
        return four ? TOTAL_WORDS - RSV_WORDS - TID_WORDS - USR_WORDS
                    : TOTAL_WORDS - RSV_WORDS - TID_WORDS;
    endfunction

    function automatic int bank_words(input bit four, input logic [1:0] b);
        case (b)
            2'b00:   return RSV_WORDS;
            2'b01:   return epc_words(four);
            2'b10:   return TID_WORDS;
            default: return four ? USR_WORDS : 0;
        endcase
    endfunction

    function automatic int bank_base(input bit four, input logic [1:0] b);
        case (b)
            2'b00:   return 0;
            2'b01:   return RSV_WORDS;
            2'b10:   return RSV_WORDS + epc_words(four);
            default: return RSV_WORDS + epc_words(four) + TID_WORDS;
        endcase
    endfunction

endpackage

// File: rtl/tbm_addr_map.sv
module tbm_addr_map
    import tbm_pkg::*;
#(
    parameter bit FOUR_BANK = 1'b0,
    parameter int PTR_W     = 8,
    parameter int CNT_W     = 8,
    parameter int AW        = 5
) (
    input  op_e              op,
    input  logic [1:0]       bank,
    input  logic [PTR_W-1:0] ptr,
    input  logic [CNT_W-1:0] cnt,
    output logic [AW-1:0]    start_addr,
    output logic [CNT_W-1:0] eff_cnt,
    output logic             ok
);

    int size;
    int base;
    int endp;

    always_comb begin
        size       = bank_words(FOUR_BANK, bank);
        base       = bank_base(FOUR_BANK, bank);
        eff_cnt    = (op == OP_WRITE) ? CNT_W'(1) : cnt;
        endp       = int'(ptr) + int'(eff_cnt);
        start_addr = AW'(base + int'(ptr));
        ok         = (eff_cnt != '0) && (size != 0) && (endp <= size);
        if (op == OP_BLKWR && int'(cnt) > BLK_MAX) begin
            ok = 1'b0;
        end
        if (op != OP_READ && bank == BANK_TID) begin
            ok = 1'b0;
        end
    end

endmodule

// File: rtl/tbm_word_array.sv
module tbm_word_array #(
    parameter int              WORDS   = 27,
    parameter int              WORD_W  = 16,
    parameter int              AW      = 5,
    parameter int              ID_ADDR = 23,
    parameter logic [WORD_W-1:0] ID_VAL = 16'hE002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= (i == ID_ADDR) ? ID_VAL : '0;
            end
        end else if (we && int'(waddr) < WORDS) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = (int'(raddr) < WORDS) ? mem[raddr] : '0;
    end

endmodule

// File: rtl/tag_bank_ctrl.sv
module tag_bank_ctrl
    import tbm_pkg::*;
#(
    parameter bit FOUR_BANK = 1'b0,
    parameter int PTR_W     = 8,
    parameter int CNT_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                req_op,
    input  logic [1:0]                req_bank,
    input  logic [PTR_W-1:0]          req_ptr,
    input  logic [CNT_W-1:0]          req_cnt,
    input  logic [BLK_MAX*WORD_W-1:0] req_wdata,
    output logic                      busy,
    output logic                      rd_valid,
    output logic [WORD_W-1:0]         rd_data,
    output logic                      done,
    output logic                      err
);

    localparam int AW       = $clog2(TOTAL_WORDS);
    localparam int IDX_W    = $clog2(BLK_MAX);
    localparam int TID_BASE = bank_base(FOUR_BANK, 2'b10);

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_STORE,
        S_DONE,
        S_FAIL
    } state_e;

    state_e            state;
    op_e               op_q;
    logic [AW-1:0]     addr;
    logic [CNT_W-1:0]  left;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] wbuf [BLK_MAX];

    logic [AW-1:0]     map_addr;
    logic [CNT_W-1:0]  map_cnt;
    logic              map_ok;
    logic              mem_we;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] arr_rdata;

    tbm_addr_map #(
        .FOUR_BANK(FOUR_BANK),
        .PTR_W    (PTR_W),
        .CNT_W    (CNT_W),
        .AW       (AW)
    ) u_map (
        .op        (op_e'(req_op)),
        .bank      (req_bank),
        .ptr       (req_ptr),
        .cnt       (req_cnt),
        .start_addr(map_addr),
        .eff_cnt   (map_cnt),
        .ok        (map_ok)
    );

    tbm_word_array #(
        .WORDS  (TOTAL_WORDS),
        .WORD_W (WORD_W),
        .AW     (AW),
        .ID_ADDR(TID_BASE),
        .ID_VAL (ID_WORD)
    ) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(addr),
        .wdata(mem_wdata),
        .raddr(addr),
        .rdata(arr_rdata)
    );

    // State register and request sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            op_q  <= OP_READ;
            addr  <= '0;
            left  <= '0;
            idx   <= '0;
            for (int i = 0; i < BLK_MAX; i++) begin
                wbuf[i] <= '0;
            end
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q <= op_e'(req_op);
                        addr <= map_addr;
                        left <= map_cnt;
                        idx  <= '0;
                        for (int i = 0; i < BLK_MAX; i++) begin
                            wbuf[i] <= req_wdata[i*WORD_W +: WORD_W];
                        end
                        if (!map_ok) begin
                            state <= S_FAIL;
                        end else if (op_e'(req_op) == OP_READ) begin
                            state <= S_READ;
                        end else begin
                            state <= S_STORE;
                        end
                    end
                end
                S_READ, S_STORE: begin
                    addr <= addr + AW'(1);
                    left <= left - CNT_W'(1);
                    idx  <= idx + IDX_W'(1);
                    if (left == CNT_W'(1)) begin
                        state <= S_DONE;
                    end
                end
                S_DONE, S_FAIL: begin
                    state <= S_IDLE;
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy      = (state != S_IDLE);
        rd_valid  = (state == S_READ);
        rd_data   = rd_valid ? arr_rdata : '0;
        done      = (state == S_DONE);
        err       = (state == S_FAIL);
        mem_we    = (state == S_STORE);
        mem_wdata = (op_q == OP_ERASE) ? '0 : wbuf[idx];
    end

endmodule

// File: rtl/tag_bank_ctrl_checker.sv
module tag_bank_ctrl_checker #(
    parameter int AW        = 5,
    parameter int TID_BASE  = 23,
    parameter int TID_WORDS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          busy,
    input logic          rd_valid,
    input logic          done,
    input logic          err,
    input logic          mem_we,
    input logic [AW-1:0] mem_waddr,
    input logic          map_ok
);

    p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    p_done_after_work_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rd_valid || mem_we));

    p_reject_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !map_ok) |=> (err && !mem_we));

    p_tid_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(int'(mem_waddr) >= TID_BASE && int'(mem_waddr) < TID_BASE + TID_WORDS));

endmodule

bind tag_bank_ctrl tag_bank_ctrl_checker #(
    .AW       (AW),
    .TID_BASE (TID_BASE),
    .TID_WORDS(tbm_pkg::TID_WORDS)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .busy     (busy),
    .rd_valid (rd_valid),
    .done     (done),
    .err      (err),
    .mem_we   (mem_we),
    .mem_waddr(addr),
    .map_ok   (map_ok)
);

// File: tb/tb_tag_bank_ctrl.sv
module tb_tag_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [1:0]  req_bank;
    logic [7:0]  req_ptr;
    logic [7:0]  req_cnt;
    logic [63:0] req_wdata;

    logic        busy3, rdv3, done3, err3;
    logic [15:0] rdd3;
    logic        busy4, rdv4, done4, err4;
    logic [15:0] rdd4;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int mdl [2][27];
    int got [2][64];
    int nrd [2];
    int dc  [2];
    int ec  [2];
    int frd [2];
    bit fin [2];

    always #10 clk = ~clk;

    tag_bank_ctrl #(.FOUR_BANK(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_ptr(req_ptr), .req_cnt(req_cnt),
        .req_wdata(req_wdata), .busy(busy3), .rd_valid(rdv3), .rd_data(rdd3),
        .done(done3), .err(err3)
    );

    tag_bank_ctrl #(.FOUR_BANK(1'b1)) dut4 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_ptr(req_ptr), .req_cnt(req_cnt),
        .req_wdata(req_wdata), .busy(busy4), .rd_valid(rdv4), .rd_data(rdd4),
        .done(done4), .err(err4)
    );

    function automatic int tb_size(input int four, input int b);
        case (b)
            0: return 4;
            1: return four ? 11 : 19;
            2: return 4;
            default: return four ? 8 : 0;
        endcase
    endfunction

    function automatic int tb_base(input int four, input int b);
        case (b)
            0: return 0;
            1: return 4;
            2: return four ? 15 : 23;
            default: return 19;
        endcase
    endfunction

    function automatic bit tb_ok(input int four, input int op, input int bank,
                                 input int ptr, input int cnt);
        int n;
        n = (op == 1) ? 1 : cnt;
        if (n == 0) return 0;
        if (tb_size(four, bank) == 0) return 0;
        if (ptr + n > tb_size(four, bank)) return 0;
        if (op == 2 && cnt > 4) return 0;
        if (op != 0 && bank == 2) return 0;
        return 1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic sample_outputs(input int c);
        if (!fin[0]) begin
            if (rdv3 && nrd[0] < 64) begin
                if (frd[0] < 0) frd[0] = c;
                got[0][nrd[0]] = int'(rdd3);
                nrd[0]++;
            end
            if (done3) begin dc[0] = c; fin[0] = 1; end
            if (err3)  begin ec[0] = c; fin[0] = 1; end
        end
        if (!fin[1]) begin
            if (rdv4 && nrd[1] < 64) begin
                if (frd[1] < 0) frd[1] = c;
                got[1][nrd[1]] = int'(rdd4);
                nrd[1]++;
            end
            if (done4) begin dc[1] = c; fin[1] = 1; end
            if (err4)  begin ec[1] = c; fin[1] = 1; end
        end
    endtask

    task automatic clear_results();
        for (int k = 0; k < 2; k++) begin
            nrd[k] = 0; dc[k] = -1; ec[k] = -1; frd[k] = -1; fin[k] = 0;
        end
    endtask

    task automatic evaluate(input int op, input int bank, input int ptr, input int cnt,
                            input logic [63:0] wd, input string tag);
        for (int k = 0; k < 2; k++) begin
            int n;
            int b;
            string t;
            string who;
            who = (k == 0) ? "[3-bank]" : "[4-bank]";
            n = (op == 1) ? 1 : cnt;
            b = tb_base(k, bank) + ptr;
            if (!tb_ok(k, op, bank, ptr, cnt)) begin
                if (tag != "") t = tag;
                else if (bank == 3 && k == 0) t = "R8";
                else if (op != 0 && bank == 2) t = "R9";
                else t = "R7";
                chk(t, {who, " err cycle"}, ec[k], 1);
                chk(t, {who, " no read words"}, nrd[k], 0);
                chk(t, {who, " no done"}, dc[k], -1);
            end else begin
                if (tag != "") t = tag;
                else if (op == 0) t = "R3";
                else if (op == 1) t = "R4";
                else if (op == 2) t = "R5";
                else t = "R6";
                chk(t, {who, " done cycle"}, dc[k], n + 1);
                chk(t, {who, " no err"}, ec[k], -1);
                if (op == 0) begin
                    chk(t, {who, " first rd_valid cycle"}, frd[k], 1);
                    chk(t, {who, " word count"}, nrd[k], n);
                    for (int i = 0; i < n && i < nrd[k]; i++) begin
                        chk(t, {who, " read word"}, got[k][i], mdl[k][b + i]);
                    end
                end else if (op == 1) begin
                    mdl[k][b] = int'(wd[15:0]);
                end else if (op == 2) begin
                    for (int i = 0; i < n; i++) mdl[k][b + i] = int'(wd[16*i +: 16]);
                end else begin
                    for (int i = 0; i < n; i++) mdl[k][b + i] = 0;
                end
            end
        end
    endtask

    task automatic run_op(input int op, input int bank, input int ptr, input int cnt,
                          input logic [63:0] wd, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op[1:0];
        req_bank  = bank[1:0];
        req_ptr   = ptr[7:0];
        req_cnt   = cnt[7:0];
        req_wdata = wd;
        clear_results();
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 1; c <= 70; c++) begin
            sample_outputs(c);
            if (fin[0] && fin[1]) break;
            @(negedge clk);
        end
        evaluate(op, bank, ptr, cnt, wd, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_bank = '0;
        req_ptr = '0; req_cnt = '0; req_wdata = '0;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 27; i++) mdl[k][i] = 0;
            mdl[k][tb_base(k, 2)] = 16'hE002;
        end
        repeat (3) @(negedge clk);
        chk("R1", "busy", int'({busy3, busy4}), 0);
        chk("R1", "rd_valid", int'({rdv3, rdv4}), 0);
        chk("R1", "done", int'({done3, done4}), 0);
        chk("R1", "err", int'({err3, err4}), 0);
        rst_n = 1'b1;

        // Reset contents
        run_op(0, 0, 0, 4, 64'h0, "R1");
        run_op(0, 1, 0, 11, 64'h0, "R1");
        run_op(0, 2, 0, 4, 64'h0, "R9");
        // Partition sizes: full item-code bank, user bank, edge pointer
        run_op(0, 1, 0, 19, 64'h0, "R2");
        run_op(0, 1, 10, 1, 64'h0, "R2");
        run_op(0, 1, 11, 1, 64'h0, "R2");
        run_op(0, 3, 0, 8, 64'h0, "R2");
        // Writes
        run_op(2, 0, 0, 4, 64'h4444_3333_2222_1111, "R5");
        run_op(0, 0, 0, 4, 64'h0, "R5");
        run_op(1, 1, 2, 9, 64'hFFFF_FFFF_FFFF_ABCD, "R4");
        run_op(0, 1, 2, 1, 64'h0, "R4");
        run_op(2, 1, 0, 0, 64'h1, "R5");
        run_op(2, 1, 0, 5, 64'h1, "R5");
        run_op(2, 3, 5, 3, 64'h0000_7777_8888_9999, "R8");
        run_op(0, 3, 5, 3, 64'h0, "R8");
        // Range errors leave memory alone
        run_op(2, 0, 2, 3, 64'hDEAD_DEAD_DEAD_DEAD, "R7");
        run_op(0, 0, 0, 4, 64'h0, "R7");
        run_op(0, 0, 0, 0, 64'h0, "R7");
        // Identification bank protection
        run_op(1, 2, 0, 1, 64'h5555, "R9");
        run_op(3, 2, 0, 4, 64'h0, "R9");
        run_op(0, 2, 0, 1, 64'h0, "R9");
        // Whole-bank erase
        run_op(2, 1, 8, 3, 64'h0000_aaaa_bbbb_cccc, "R5");
        run_op(3, 1, 0, 19, 64'h0, "R6");
        run_op(0, 1, 0, 11, 64'h0, "R6");

        // Request held during a read is ignored
        run_op(2, 0, 0, 4, 64'h0404_0303_0202_0101, "R5");
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_bank = 2'd1; req_ptr = 8'd0; req_cnt = 8'd3;
        clear_results();
        @(negedge clk);
        req_op = 2'd3; req_bank = 2'd0; req_ptr = 8'd0; req_cnt = 8'd4;
        chk("R10", "busy while reading", int'({busy3, busy4}), 3);
        sample_outputs(1);
        @(negedge clk);
        sample_outputs(2);
        req_valid = 1'b0;
        for (int c = 3; c <= 10; c++) begin
            @(negedge clk);
            sample_outputs(c);
        end
        chk("R10", "done cycle 3-bank", dc[0], 4);
        chk("R10", "done cycle 4-bank", dc[1], 4);
        chk("R10", "no err", ec[0] + ec[1], -2);
        chk("R10", "idle after done", int'({busy3, busy4}), 0);
        run_op(0, 0, 0, 4, 64'h0, "R10");

        // Constrained random traffic
        for (int j = 0; j < 400; j++) begin
            int op, bank, ptr, cnt;
            op   = int'($urandom % 4);
            bank = int'($urandom % 4);
            ptr  = int'($urandom % 22);
            cnt  = int'($urandom % 7);
            if (op == 3 && ($urandom % 2) == 1) cnt = int'($urandom % 21);
            run_op(op, bank, ptr, cnt, {$urandom, $urandom}, "");
        end
        run_op(0, 1, 0, 19, 64'h0, "R3");
        run_op(0, 3, 0, 8, 64'h0, "R3");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule